// File: doc/BRIEF.md
# Round-Robin Shared-Pin Bus Arbiter

This block decides which of N masters may drive a single set of external bus pins that all of them share. Every master has a private request line and a private grant line. When several masters want the bus together, ownership passes among them in a rotating order. The search for the next owner starts at the master just past the one that held the bus last.

A request has two meanings, and the master's own grant decides which one applies. While the grant is low, a high request asks for the bus. While the grant is high, a high request asks to keep the bus for one more cycle. An owner therefore lowers its request during the last cycle it wants. Its grant then falls one cycle later, so the shortest tenure is two granted cycles.

The block also outputs a binary owner index and a bus-active flag. A downstream multiplexer uses these to steer the shared pins. When nobody requests, no master is granted.

Top module: `rr_pin_arbiter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives all grants low, `sel` to 0 and `bus_active` low. Afterwards the rotating search starts at master 0, so if every master requests together, master 0 wins first.
- R2: With no current owner, a request sampled high at a clock edge raises that master's grant in the very next cycle. In the same cycle `bus_active` goes high and `sel` carries the master's index.
- R3: While a master holds the grant and its request is high at a clock edge, it keeps the grant for the following cycle.
- R4: When the owner's request is low at a clock edge, its grant is low after that edge. Because a request must stay high until granted, a tenure lasts at least two granted cycles.
- R5: At most one grant is high in any cycle. `bus_active` is high exactly when some grant is high. While `bus_active` is high, `sel` is the binary index (bit position in `gnt`) of the granted master; otherwise it is 0.
- R6: Among masters that are requesting, the new owner is the first one found by searching upward from the index one past the last owner. The search wraps from N-1 back to 0.
- R7: If another master is requesting at the edge where the owner releases, the new grant rises in the cycle right after the old owner's last granted cycle. No idle cycle falls between the two tenures.
- R8: When no master requests, no grant is high. A master whose request is low never receives a grant.
- R9: A master may raise its request again in the cycle after its final granted cycle. If no other master is requesting, it is granted again after exactly one cycle without a grant.
- R10: A request from a master that does not own the bus does not take the bus from the current owner. That master waits until the owner releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Request line for each master; bit i belongs to master i |
| gnt | output | N | Grant line for each master; bit i belongs to master i |
| sel | output | IW | Binary index of the current owner, 0 when idle |
| bus_active | output | 1 | High while some master owns the bus |

## Verification
The hardest situation to reach from the ports is a release that happens while other masters are queued. The rotating pointer, the wrap from the top index back to 0 and the gapless handover all act at that one clock edge. The stimulus gets there by raising every request at once right after reset. Each master then drops its request after a short tenure, which walks ownership across all indices. A later sequence sets the pointer near the top index and queues a low-index master, forcing the wrap. A per-cycle reference model built from the requirements predicts every grant vector. The bench feeds those predictions through a scoreboard queue.

// File: rtl/arb_pkg.sv
package arb_pkg;

   // Index following idx in a ring of n positions
   function automatic int ring_next(input int idx, input int n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter int N          = 4,
   parameter bit MASK_STYLE = 1'b1,
   localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] start,
   output logic          found,
   output logic [IW-1:0] idx
);

   generate
      if (MASK_STYLE) begin : g_mask
         // keep requesters at or above start; fall back to all requesters
         logic [N-1:0] upper;
         logic [N-1:0] src;
         always_comb begin
            for (int i = 0; i < N; i++)
               upper[i] = req[i] && (i >= int'(start));
            src   = (|upper) ? upper : req;
            found = |req;
            idx   = '0;
            for (int i = N - 1; i >= 0; i--)
               if (src[i]) idx = IW'(i);
         end
      end else begin : g_scan
         // walk the ring from start, first hit wins
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int k = 0; k < N; k++) begin
               int j;
               j = int'(start) + k;
               if (j >= N) j = j - N;
               if (!found && req[j]) begin
                  found = 1'b1;
                  idx   = IW'(j);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/arb_owner_reg.sv
module arb_owner_reg
   import arb_pkg::*;
#(
   parameter int N   = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  req,
   input  logic          pick_found,
   input  logic [IW-1:0] pick_idx,
   output logic          busy,
   output logic [IW-1:0] owner,
   output logic [IW-1:0] ptr
);

   logic keep;

   // owner with request still high claims the next cycle
   assign keep = busy && req[owner];

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         owner <= '0;
         ptr   <= '0;
      end else if (!keep) begin
         busy <= pick_found;
         if (pick_found) begin
            owner <= pick_idx;
            ptr   <= IW'(ring_next(int'(pick_idx), N));
         end
      end
   end

endmodule

// File: rtl/rr_pin_arbiter.sv
module rr_pin_arbiter #(
   parameter int N          = 4,
   parameter bit MASK_STYLE = 1'b1,
   localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] sel,
   output logic          bus_active
);

   generate
      if (N < 2) begin : g_bad_n
         $error("rr_pin_arbiter: N must be at least 2");
      end
   endgenerate

   logic          pick_found;
   logic [IW-1:0] pick_idx;
   logic          busy;
   logic [IW-1:0] owner;
   logic [IW-1:0] ptr;

   arb_rr_pick #(.N(N), .MASK_STYLE(MASK_STYLE)) u_pick (
      .req   (req),
      .start (ptr),
      .found (pick_found),
      .idx   (pick_idx)
   );

   arb_owner_reg #(.N(N)) u_owner (
      .clk        (clk),
      .rst        (rst),
      .req        (req),
      .pick_found (pick_found),
      .pick_idx   (pick_idx),
      .busy       (busy),
      .owner      (owner),
      .ptr        (ptr)
   );

   generate
      for (genvar g = 0; g < N; g++) begin : g_gnt
         assign gnt[g] = busy && (owner == IW'(g));
      end
   endgenerate

   assign sel        = busy ? owner : '0;
   assign bus_active = busy;

endmodule

// File: rtl/rr_pin_arbiter_chk.sv
module rr_pin_arbiter_chk #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input logic          clk,
   input logic          rst,
   input logic [N-1:0]  req,
   input logic [N-1:0]  gnt,
   input logic [IW-1:0] sel,
   input logic          bus_active
);

   assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt));

   assert_flag_R5: assert property (@(posedge clk) disable iff (rst)
      bus_active == (gnt != '0));

   assert_sel_R5: assert property (@(posedge clk) disable iff (rst)
      bus_active |-> gnt[sel]);

   assert_serve_R2: assert property (@(posedge clk) disable iff (rst)
      (!bus_active && req != '0) |=> bus_active);

   assert_handover_R7: assert property (@(posedge clk) disable iff (rst)
      (bus_active && !req[sel] && req != '0) |=> bus_active);

   generate
      for (genvar i = 0; i < N; i++) begin : g_per
         assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (gnt[i] && req[i]) |=> gnt[i]);

         assert_release_R4: assert property (@(posedge clk) disable iff (rst)
            (gnt[i] && !req[i]) |=> !gnt[i]);

         assert_no_unrequested_R8: assert property (@(posedge clk) disable iff (rst)
            (!gnt[i] && !req[i]) |=> !gnt[i]);
      end
   endgenerate

endmodule

bind rr_pin_arbiter rr_pin_arbiter_chk #(.N(N), .IW(IW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req        (req),
   .gnt        (gnt),
   .sel        (sel),
   .bus_active (bus_active)
);

// File: tb/rr_pin_arbiter_tb.sv
module rr_pin_arbiter_tb;

   localparam int  N          = 4;
   localparam int  IW         = 2;
   localparam time CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  req = '0;
   logic [N-1:0]  gnt;
   logic [IW-1:0] sel;
   logic          bus_active;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // scoreboard queues, one entry per predicted cycle
   logic [N-1:0]  q_gnt[$];
   logic [IW-1:0] q_sel[$];
   logic          q_act[$];
   string         q_tag[$];

   // reference state built from the requirements
   bit m_busy = 1'b0;
   int m_own  = 0;
   int m_ptr  = 0;

   rr_pin_arbiter #(.N(N)) u_dut (
      .clk        (clk),
      .rst        (rst),
      .req        (req),
      .gnt        (gnt),
      .sel        (sel),
      .bus_active (bus_active)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic step(input logic [N-1:0] r, input string tag);
      logic [N-1:0] eg;
      @(negedge clk);
      req = r;
      if (!(m_busy && r[m_own])) begin
         m_busy = 1'b0;
         for (int k = 0; k < N; k++) begin
            int j;
            j = (m_ptr + k) % N;
            if (!m_busy && r[j]) begin
               m_busy = 1'b1;
               m_own  = j;
            end
         end
         if (m_busy) m_ptr = (m_own + 1) % N;
      end
      eg = m_busy ? (N'(1) << m_own) : '0;
      q_gnt.push_back(eg);
      q_sel.push_back(m_busy ? IW'(m_own) : '0);
      q_act.push_back(m_busy);
      q_tag.push_back(tag);
   endtask

   // monitor: compare just after each rising edge
   initial begin
      wait (!rst);
      forever begin
         @(posedge clk);
         #1;
         if (q_gnt.size() > 0) begin
            logic [N-1:0]  eg;
            logic [IW-1:0] es;
            logic          ea;
            string         t;
            eg = q_gnt.pop_front();
            es = q_sel.pop_front();
            ea = q_act.pop_front();
            t  = q_tag.pop_front();
            total++;
            if (gnt !== eg || sel !== es || bus_active !== ea) begin
               bad++;
               $display("FAIL %s: gnt=%b sel=%0d act=%b expected gnt=%b sel=%0d act=%b",
                        t, gnt, sel, bus_active, eg, es, ea);
            end
            total++;
            if (!$onehot0(gnt)) begin
               bad++;
               $display("FAIL R5: gnt=%b expected at most one bit set", gnt);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      total++;
      if (gnt !== '0 || sel !== '0 || bus_active !== 1'b0) begin
         bad++;
         $display("FAIL R1: gnt=%b sel=%0d act=%b expected gnt=0 sel=0 act=0",
                  gnt, sel, bus_active);
      end
      @(negedge clk);
      rst = 1'b0;

      // R8: nobody asks, nobody is granted
      repeat (3) step(4'b0000, "R8");

      // R1 / R6 / R7: all at once after reset, two-cycle tenures, gapless handover
      step(4'b1111, "R1");
      step(4'b1111, "R3");
      step(4'b1110, "R7");
      step(4'b1110, "R6");
      step(4'b1100, "R7");
      step(4'b1100, "R6");
      step(4'b1000, "R7");
      step(4'b1000, "R4");
      step(4'b0000, "R4");
      step(4'b0000, "R8");

      // R3 / R10: long tenure of master 2 while master 0 waits
      step(4'b0100, "R2");
      step(4'b0100, "R3");
      step(4'b0101, "R10");
      step(4'b0101, "R10");
      step(4'b0101, "R3");
      step(4'b0001, "R7");
      step(4'b0001, "R3");
      step(4'b0000, "R4");
      step(4'b0000, "R8");

      // R9: same master re-requests right after its final cycle
      step(4'b0010, "R2");
      step(4'b0010, "R3");
      step(4'b0000, "R4");
      step(4'b0010, "R9");
      step(4'b0010, "R9");
      step(4'b0000, "R4");
      step(4'b0000, "R8");

      // R6: pointer at 2, masters 3 and 0 waiting, then wrap to 0
      step(4'b1001, "R6");
      step(4'b1001, "R3");
      step(4'b0001, "R6");
      step(4'b0001, "R3");
      step(4'b0000, "R4");
      step(4'b1010, "R6");
      step(4'b1010, "R3");
      step(4'b1000, "R7");
      step(4'b1000, "R3");
      step(4'b0000, "R4");
      step(4'b0000, "R8");

      repeat (3) @(negedge clk);
      done = 1'b1;
      total++;
      if (q_gnt.size() != 0) begin
         bad++;
         $display("FAIL R5: pending=%0d expected=0", q_gnt.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule